// File: doc/BRIEF.md
# Float Rounding-Mode Resolution and Sticky Flag Control

This block sits beside a single-precision floating-point datapath. Each cycle it works out which rounding mode an operation should use: it takes the 3-bit rounding field from the instruction, or the dynamic mode register when that field asks for it. It refuses encodings that name no rounding mode. It also finishes each arithmetic result: a result that reports an invalid operation is replaced by the canonical quiet NaN.

The block keeps the five accumulated exception flags. Every accepted result ORs its exception bits into the flag register. A control-register port can read the register at any time and can overwrite it. The illegal-instruction request is combinational from the two rounding inputs, so the pipeline can squash the operation in the cycle it is presented. The trap handler turns that request into exception cause 2.

Top module: `fp_round_flag_ctrl`

## Requirements
- R1: When `op_rm` is 0 to 4, `rm_res` equals `op_rm` and `illegal_req` is 0, in the same cycle. The encodings are 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest with ties away from zero.
- R2: When `op_rm` is 7, `rm_res` equals `dyn_rm`, and legality is judged on `dyn_rm`.
- R3: When the effective code (the value on `rm_res`) is 5, 6 or 7, `illegal_req` is 1 combinationally in the same cycle.
- R4: While `illegal_req` is 1, a result strobe leaves `flags` unchanged.
- R5: Flag bits are inexact at bit 0, underflow at bit 1, overflow at bit 2, divide-by-zero at bit 3 and invalid at bit 4. An accepted result (`res_valid`=1, `illegal_req`=0) sets `flags` to its old value OR `res_exc` at the next edge. No operation ever clears a bit.
- R6: With `res_valid` at 0 and no control-register write, `flags` keeps its value whatever `res_exc` holds.
- R7: When `res_valid` is 1 and `res_exc` bit 4 is 1, `res_final` is 0x7FC00000. Otherwise `res_final` equals `res_raw`.
- R8: When `csr_we` is 1, `flags` takes `csr_wdata` at the next edge, even if a result is accepted in the same cycle.
- R9: After reset, `flags` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_rm | input | 3 | Rounding field from the instruction |
| dyn_rm | input | 3 | Dynamic rounding-mode register value |
| res_valid | input | 1 | Result strobe for this cycle |
| res_exc | input | 5 | Exception bits of this result |
| res_raw | input | 32 | Result from the datapath |
| csr_we | input | 1 | Control-register write to the flag register |
| csr_wdata | input | 5 | Value written to the flag register |
| rm_res | output | 3 | Resolved rounding-mode code |
| illegal_req | output | 1 | Illegal-instruction request |
| res_final | output | 32 | Result after NaN substitution |
| flags | output | 5 | Sticky flag register, also the read port |

## Verification
The bench builds the block with its default parameters: a 32-bit result, five flags and 0x7FC00000 as the canonical NaN. With these values every rounding code on both inputs can be exercised in full, all eight values of each. Every flag bit position can be set on its own. The NaN substitution can be told apart from a pass-through of a raw value that merely resembles a NaN. Collisions between a control-register write and an accepted or refused result are driven on purpose, to pin down the write priority.

// File: rtl/fprm_pkg.sv
package fprm_pkg;
    localparam int RM_W = 3;

    typedef enum logic [RM_W-1:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_TO_ZERO   = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_MAX  = 3'd4,
        RM_BAD5      = 3'd5,
        RM_BAD6      = 3'd6,
        RM_DYNAMIC   = 3'd7
    } rm_code_e;

    localparam int FLG_NX = 0;
    localparam int FLG_UF = 1;
    localparam int FLG_OF = 2;
    localparam int FLG_DZ = 3;
    localparam int FLG_NV = 4;
endpackage

// File: rtl/fprm_resolve.sv
module fprm_resolve
    import fprm_pkg::*;
(
    input  logic [RM_W-1:0] op_rm,
    input  logic [RM_W-1:0] dyn_rm,
    output logic [RM_W-1:0] eff_rm,
    output logic            bad_rm
);
    rm_code_e sel;

    always_comb begin
        sel = rm_code_e'(op_rm);
        if (sel == RM_DYNAMIC) begin
            sel = rm_code_e'(dyn_rm);
        end
        eff_rm = sel;
        unique case (sel)
            RM_NEAR_EVEN, RM_TO_ZERO, RM_DOWN,
            RM_UP, RM_NEAR_MAX:               bad_rm = 1'b0;
            RM_BAD5, RM_BAD6, RM_DYNAMIC:     bad_rm = 1'b1;
            default:                          bad_rm = 1'b1;
        endcase
    end
endmodule

// File: rtl/fprm_nan_sub.sv
module fprm_nan_sub #(
    parameter int              DATA_W    = 32,
    parameter logic [DATA_W-1:0] CANON_NAN = 32'h7FC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              invalid,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] final_q
);
    always_comb begin
        final_q = (valid && invalid) ? CANON_NAN : raw;
    end

    always @(posedge clk) begin
        if (rst_n && valid && invalid) begin
            AST_NAN_SUBST: assert (final_q == CANON_NAN); // R7
        end
        if (rst_n && !valid) begin
            AST_RAW_PASS: assert (final_q == raw); // R7
        end
    end
endmodule

// File: rtl/fprm_flags.sv
module fprm_flags #(
    parameter int FLAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [FLAG_W-1:0] upd_bits,
    input  logic              csr_we,
    input  logic [FLAG_W-1:0] csr_wdata,
    output logic [FLAG_W-1:0] flags_q
);
    logic [FLAG_W-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (csr_we) begin
            flags_d = csr_wdata;
        end else if (upd_en) begin
            flags_d = flags_q | upd_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    AST_CSR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> flags_q == $past(csr_wdata)); // R8
    AST_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> ($past(flags_q) & ~flags_q) == '0); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_we && !upd_en) |=> $stable(flags_q)); // R6
endmodule

// File: rtl/fp_round_flag_ctrl.sv
module fp_round_flag_ctrl
    import fprm_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                FLAG_W    = 5,
    parameter logic [DATA_W-1:0] CANON_NAN = 32'h7FC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_rm,
    input  logic [2:0]        dyn_rm,
    input  logic              res_valid,
    input  logic [FLAG_W-1:0] res_exc,
    input  logic [DATA_W-1:0] res_raw,
    input  logic              csr_we,
    input  logic [FLAG_W-1:0] csr_wdata,
    output logic [2:0]        rm_res,
    output logic              illegal_req,
    output logic [DATA_W-1:0] res_final,
    output logic [FLAG_W-1:0] flags
);
    logic accept;

    fprm_resolve u_resolve (
        .op_rm  (op_rm),
        .dyn_rm (dyn_rm),
        .eff_rm (rm_res),
        .bad_rm (illegal_req)
    );

    assign accept = res_valid && !illegal_req;

    fprm_nan_sub #(
        .DATA_W    (DATA_W),
        .CANON_NAN (CANON_NAN)
    ) u_nan (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (res_valid),
        .invalid (res_exc[FLG_NV]),
        .raw     (res_raw),
        .final_q (res_final)
    );

    fprm_flags #(
        .FLAG_W (FLAG_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (accept),
        .upd_bits  (res_exc),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .flags_q   (flags)
    );

    AST_ILLEGAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_req && !csr_we) |=> $stable(flags)); // R4

    always @(posedge clk) begin
        if (rst_n && !illegal_req) begin
            AST_RM_IN_RANGE: assert (rm_res <= 3'd4); // R1
        end
        if (rst_n && op_rm != 3'd7) begin
            AST_STATIC_PASS: assert (rm_res == op_rm); // R1
        end
    end
endmodule

// File: tb/fp_round_flag_ctrl_tb.sv
`timescale 1ns/1ps
module fp_round_flag_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_rm = '0, dyn_rm = '0;
    logic        res_valid = 1'b0;
    logic [4:0]  res_exc = '0;
    logic [31:0] res_raw = '0;
    logic        csr_we = 1'b0;
    logic [4:0]  csr_wdata = '0;
    logic [2:0]  rm_res;
    logic        illegal_req;
    logic [31:0] res_final;
    logic [4:0]  flags;

    int n_run = 0;
    int n_fail = 0;
    logic [4:0] m_flags = '0;
    bit done = 0;

    typedef struct {
        logic [2:0]  rm;
        logic        ill;
        logic [31:0] res;
        logic [4:0]  flg;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #4 clk = ~clk;

    fp_round_flag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .op_rm(op_rm), .dyn_rm(dyn_rm),
        .res_valid(res_valid), .res_exc(res_exc), .res_raw(res_raw),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .rm_res(rm_res),
        .illegal_req(illegal_req), .res_final(res_final), .flags(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic [2:0] d, input logic v,
                         input logic [4:0] e, input logic [31:0] r,
                         input logic we, input logic [4:0] wd, input string tag);
        item_t it;
        logic [2:0] eff;
        logic bad;
        @(posedge clk); #2;
        op_rm = o; dyn_rm = d; res_valid = v; res_exc = e; res_raw = r;
        csr_we = we; csr_wdata = wd;
        eff = (o == 3'd7) ? d : o;
        bad = (eff > 3'd4);
        it.rm = eff; it.ill = bad;
        it.res = (v && e[4]) ? 32'h7FC0_0000 : r;
        it.flg = m_flags;
        it.tag = tag;
        sbq.push_back(it);
        if (we) m_flags = wd;
        else if (v && !bad) m_flags = m_flags | e;
    endtask

    always @(negedge clk) begin
        if (rst_n && sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            chk({it.tag, " rm"}, {29'd0, rm_res}, {29'd0, it.rm});
            chk({it.tag, " ill"}, {31'd0, illegal_req}, {31'd0, it.ill});
            chk({it.tag, " res"}, res_final, it.res);
            chk({it.tag, " flags"}, {27'd0, flags}, {27'd0, it.flg});
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset flags", {27'd0, flags}, 32'd0);
        // R1 static codes, R7 pass-through and NaN
        for (int k = 0; k < 5; k++)
            drive(k[2:0], 3'd6, 1'b0, 5'h00, 32'h3F80_0000 + k, 1'b0, 5'h0, "R1 static");
        drive(3'd0, 3'd0, 1'b1, 5'h01, 32'h4000_0000, 1'b0, 5'h0, "R5 nx bit0");
        drive(3'd1, 3'd0, 1'b1, 5'h10, 32'h1234_5678, 1'b0, 5'h0, "R7 invalid nan");
        drive(3'd2, 3'd0, 1'b1, 5'h02, 32'h7F80_0001, 1'b0, 5'h0, "R7 raw pass");
        // R2 dynamic codes, all values
        for (int k = 0; k < 8; k++)
            drive(3'd7, k[2:0], 1'b0, 5'h1F, 32'hAAAA_0000 + k, 1'b0, 5'h0, "R2 dyn");
        // R3 illegal static codes
        drive(3'd5, 3'd0, 1'b0, 5'h0, 32'h1, 1'b0, 5'h0, "R3 code5");
        drive(3'd6, 3'd0, 1'b0, 5'h0, 32'h2, 1'b0, 5'h0, "R3 code6");
        // R4 illegal result does not update
        drive(3'd7, 3'd5, 1'b1, 5'h08, 32'h3, 1'b0, 5'h0, "R4 ill dyn");
        drive(3'd6, 3'd0, 1'b1, 5'h04, 32'h4, 1'b0, 5'h0, "R4 ill static");
        drive(3'd0, 3'd0, 1'b0, 5'h0, 32'h5, 1'b0, 5'h0, "R4 after");
        // R6 no strobe
        drive(3'd0, 3'd0, 1'b0, 5'h1F, 32'h6, 1'b0, 5'h0, "R6 idle");
        drive(3'd0, 3'd0, 1'b0, 5'h00, 32'h7, 1'b0, 5'h0, "R6 after");
        // R5 accumulation, each bit
        drive(3'd3, 3'd0, 1'b1, 5'h04, 32'h8, 1'b0, 5'h0, "R5 of bit2");
        drive(3'd7, 3'd4, 1'b1, 5'h08, 32'h9, 1'b0, 5'h0, "R5 dz bit3");
        drive(3'd4, 3'd0, 1'b1, 5'h00, 32'hA, 1'b0, 5'h0, "R5 no clear");
        // R8 write and priority
        drive(3'd0, 3'd0, 1'b0, 5'h0, 32'hB, 1'b1, 5'h00, "R8 clear write");
        drive(3'd0, 3'd0, 1'b1, 5'h1F, 32'hC, 1'b1, 5'h02, "R8 write wins");
        drive(3'd5, 3'd0, 1'b1, 5'h10, 32'hD, 1'b1, 5'h11, "R8 write on illegal");
        drive(3'd0, 3'd0, 1'b1, 5'h02, 32'hE, 1'b0, 5'h0, "R5 uf bit1");
        drive(3'd0, 3'd0, 1'b0, 5'h0, 32'hF, 1'b0, 5'h0, "R5 final");
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5 R8 end flags", {27'd0, flags}, {27'd0, m_flags});
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule